// File: doc/BRIEF.md
# Reversible-Connector Lane Steering Controller

This block sits between a multi-lane link encoder and four physical transceiver lanes behind a connector that can be plugged in either way round. It receives the orientation seen by an external detector and the number of active lanes (1, 2 or 4). From these it decides which encoder lane feeds each physical lane, which physical lanes are enabled, and which physical lane acts as the bonding master for the transceiver.

When either setting changes, the block does not switch on the spot. It first disables every lane so that only idle symbols leave. It then asks the transceiver to rebond around the new master lane and waits for an acknowledge. Only after the acknowledge does it move the crossbar, and it turns the lanes on one cycle later. Traffic therefore never flows while the transceiver is still bonded to the old master. If no acknowledge arrives within a programmable number of cycles, the block raises a sticky error and keeps the lanes off until the settings change again.

Top module: `lane_steer_ctrl`

## Requirements
- R1: While reset is asserted, and until the first handover completes, all lane enables are 0, the request and the error flag are 0, both master indices are 0 and every physical lane carries the idle symbol.
- R2: Lane count coding on `lane_cnt_i`: 0 selects one lane, 1 selects two lanes, 2 and 3 select four lanes. In normal orientation (`flip_i`=0) with n active lanes, encoder lane k drives physical lane k for k<n, and physical lanes n and above are disabled.
- R3: In flipped orientation (`flip_i`=1) with n active lanes, encoder lane k drives physical lane 3-k for k<n. Physical lanes below 4-n are disabled: four lanes use all of them, two lanes use 3 and 2, one lane uses 3.
- R4: The bonding master is physical lane 0 in normal orientation and physical lane 3 in flipped orientation, for every lane count. It is always an enabled lane. `reconf_master_o` carries the target master while a request is pending, and `master_o` changes only while all lanes are disabled.
- R5: A change of `flip_i` or `lane_cnt_i` seen on a clock edge (while running, or idle after an error) clears all lane enables at that edge. `reconf_req_o` rises at the next edge, together with the new master on `reconf_master_o`.
- R6: `reconf_req_o` stays high until `reconf_ack_i` is sampled high. At that edge the request drops and the crossbar and `master_o` take the new configuration. The lane enables for that configuration turn on at the following edge.
- R7: If the acknowledge has not come after max(`timeout_i`,1) request cycles, the request drops, `err_o` is set and stays set until reset, and the lanes stay disabled until the settings change again.
- R8: An acknowledge outside a pending request has no effect. A settings change made during a handover is applied by a fresh handover after the current one ends.
- R9: After reset is released, the block runs a handover for the settings present on its inputs without needing any input change.
- R10: Every disabled physical lane outputs the idle symbol `IDLE_SYM`, whatever the encoder lanes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flip_i | input | 1 | Connector orientation from the external detector, 1 = flipped |
| lane_cnt_i | input | 2 | Active lane count code (0: one, 1: two, 2/3: four) |
| timeout_i | input | TMO_W | Acknowledge wait limit in cycles |
| src_sym_i | input | 4*SYM_W | Encoder lane symbols, lane k in bits [k*SYM_W +: SYM_W] |
| reconf_ack_i | input | 1 | Transceiver rebonding done |
| phy_sym_o | output | 4*SYM_W | Symbols to physical lanes, lane p in bits [p*SYM_W +: SYM_W] |
| lane_en_o | output | 4 | Physical lane enables |
| master_o | output | 2 | Bonding master of the applied configuration |
| reconf_req_o | output | 1 | Rebonding request to the transceiver |
| reconf_master_o | output | 2 | Master index that goes with the request |
| err_o | output | 1 | Sticky acknowledge timeout flag |

## Verification
Every setting pair is visited: both orientations with one, two and four lanes, and both four-lane codes. This separates straight from reversed mapping and shows which lanes are left idle, while encoder symbols change every cycle so that a wrong crossbar leg shows up at once. Acknowledge delays of zero, two and six cycles, and an acknowledge that never comes, tell apart correct request holding, the one-cycle gap between mux switch and enable, and the timeout with its sticky flag, including a zero limit. Stray acknowledges while running, and settings changed in the middle of a pending request, show that only a live request is closed and that the last settings win.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int NL = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_QUIET = 3'd2,
        ST_WAIT  = 3'd3,
        ST_EN    = 3'd4
    } state_t;

    typedef struct packed {
        logic       flip;
        logic [1:0] cnt;
    } cfg_t;

    // Physical lanes carrying traffic for a configuration.
    function automatic logic [NL-1:0] lane_mask(cfg_t c);
        logic [NL-1:0] m;
        case (c.cnt)
            2'd0:    m = 4'b0001;
            2'd1:    m = 4'b0011;
            default: m = 4'b1111;
        endcase
        return c.flip ? {m[0], m[1], m[2], m[3]} : m;
    endfunction

    // Bonding master sits on the lane fed by encoder lane 0.
    function automatic logic [1:0] master_of(cfg_t c);
        return c.flip ? 2'd3 : 2'd0;
    endfunction

    // Encoder lane feeding physical lane p.
    function automatic logic [1:0] src_of(cfg_t c, logic [1:0] p);
        return c.flip ? (2'd3 - p) : p;
    endfunction

endpackage

// File: rtl/lsc_seq.sv
module lsc_seq
    import lsc_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic             ack_i,
    output logic [NL-1:0]    en_o,
    output logic             req_o,
    output logic [1:0]       rmaster_o,
    output cfg_t             act_o,
    output logic             err_o
);

    typedef struct packed {
        state_t           st;
        logic             valid;
        cfg_t             tgt;
        cfg_t             act;
        logic [NL-1:0]    en;
        logic             req;
        logic [1:0]       rmaster;
        logic [TMO_W-1:0] cnt;
        logic             err;
    } seq_t;

    seq_t           r_d, r_q;
    logic [TMO_W:0] cnt_inc;
    logic           cfg_new;

    assign cnt_inc = {1'b0, r_q.cnt} + 1'b1;
    assign cfg_new = !r_q.valid || (cfg_i != r_q.tgt);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE, ST_RUN: begin
                if (cfg_new) begin
                    r_d.tgt   = cfg_i;
                    r_d.valid = 1'b1;
                    r_d.en    = '0;
                    r_d.st    = ST_QUIET;
                end
            end
            ST_QUIET: begin
                r_d.req     = 1'b1;
                r_d.rmaster = master_of(r_q.tgt);
                r_d.cnt     = '0;
                r_d.st      = ST_WAIT;
            end
            ST_WAIT: begin
                if (ack_i) begin
                    r_d.req = 1'b0;
                    r_d.act = r_q.tgt;
                    r_d.st  = ST_EN;
                end else if (cnt_inc >= {1'b0, timeout_i}) begin
                    r_d.req = 1'b0;
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.cnt = cnt_inc[TMO_W-1:0];
                end
            end
            ST_EN: begin
                r_d.en = lane_mask(r_q.act);
                r_d.st = ST_RUN;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o      = r_q.en;
    assign req_o     = r_q.req;
    assign rmaster_o = r_q.rmaster;
    assign act_o     = r_q.act;
    assign err_o     = r_q.err;

    assert_req_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.req |-> (r_q.en == '0));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    assert_req_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.req) |-> ($past(ack_i) || r_q.err));

    assert_master_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.act != $past(r_q.act)) |-> ((r_q.en == '0) && ($past(r_q.en) == '0)));

    assert_master_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en != '0) |-> r_q.en[master_of(r_q.act)]);

    assert_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && (r_q.st != ST_WAIT)) |=> $stable(r_q.act));

endmodule

// File: rtl/lsc_xbar.sv
module lsc_xbar
    import lsc_pkg::*;
#(
    parameter int               SYM_W    = 10,
    parameter logic [SYM_W-1:0] IDLE_SYM = '0
) (
    input  cfg_t                  act_i,
    input  logic [NL-1:0]         en_i,
    input  logic [NL*SYM_W-1:0]   src_i,
    output logic [NL*SYM_W-1:0]   phy_o
);

    for (genvar p = 0; p < NL; p++) begin : g_lane
        logic [1:0] sel;
        assign sel = src_of(act_i, 2'(p));
        assign phy_o[p*SYM_W +: SYM_W] = en_i[p] ? src_i[sel*SYM_W +: SYM_W] : IDLE_SYM;
    end

endmodule

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
    import lsc_pkg::*;
#(
    parameter int               SYM_W    = 10,
    parameter int               TMO_W    = 16,
    parameter logic [SYM_W-1:0] IDLE_SYM = 10'h17C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flip_i,
    input  logic [1:0]          lane_cnt_i,
    input  logic [TMO_W-1:0]    timeout_i,
    input  logic [4*SYM_W-1:0]  src_sym_i,
    input  logic                reconf_ack_i,
    output logic [4*SYM_W-1:0]  phy_sym_o,
    output logic [3:0]          lane_en_o,
    output logic [1:0]          master_o,
    output logic                reconf_req_o,
    output logic [1:0]          reconf_master_o,
    output logic                err_o
);

    cfg_t cfg_in;
    cfg_t act;

    assign cfg_in.flip = flip_i;
    assign cfg_in.cnt  = lane_cnt_i;

    lsc_seq #(.TMO_W(TMO_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg_in),
        .timeout_i (timeout_i),
        .ack_i     (reconf_ack_i),
        .en_o      (lane_en_o),
        .req_o     (reconf_req_o),
        .rmaster_o (reconf_master_o),
        .act_o     (act),
        .err_o     (err_o)
    );

    lsc_xbar #(.SYM_W(SYM_W), .IDLE_SYM(IDLE_SYM)) u_xbar (
        .act_i (act),
        .en_i  (lane_en_o),
        .src_i (src_sym_i),
        .phy_o (phy_sym_o)
    );

    assign master_o = master_of(act);

endmodule

// File: tb/lane_steer_ctrl_test.sv
module lane_steer_ctrl_test;

    localparam int          SW   = 10;
    localparam logic [9:0]  IDLE = 10'h17C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flip_i = 1'b0;
    logic [1:0]  lane_cnt_i = 2'd2;
    logic [15:0] timeout_i = 16'd20;
    logic [39:0] src_sym_i = '0;
    logic        reconf_ack_i = 1'b0;
    logic [39:0] phy_sym_o;
    logic [3:0]  lane_en_o;
    logic [1:0]  master_o;
    logic        reconf_req_o;
    logic [1:0]  reconf_master_o;
    logic        err_o;

    int n_chk = 0, n_fail = 0;
    int ack_delay = 2;
    bit spur = 0;

    lane_steer_ctrl uut (.*);

    always #5 clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // ---------- behavioural reference ----------
    int m_st = 0;               // 0 idle,1 run,2 quiet,3 wait,4 enable
    bit m_valid = 0, m_tf = 0, m_af = 0, m_req = 0, m_err = 0;
    int m_tc = 0, m_ac = 0, m_cnt = 0, m_rm = 0;
    logic [3:0] m_en = '0;

    function automatic int nlanes(int c);
        return (c == 0) ? 1 : (c == 1) ? 2 : 4;
    endfunction

    function automatic logic [3:0] mask_of(bit f, int c);
        logic [3:0] m = '0;
        for (int k = 0; k < nlanes(c); k++) m[f ? 3 - k : k] = 1'b1;
        return m;
    endfunction

    function automatic logic [39:0] exp_phy(logic [3:0] en, bit f, int c, logic [39:0] src);
        logic [39:0] o;
        for (int p = 0; p < 4; p++) o[p*SW +: SW] = IDLE;
        for (int k = 0; k < nlanes(c); k++) begin
            int p = f ? 3 - k : k;
            if (en[p]) o[p*SW +: SW] = src[k*SW +: SW];
        end
        return o;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_valid = 0; m_tf = 0; m_af = 0; m_req = 0; m_err = 0;
            m_tc = 0; m_ac = 0; m_cnt = 0; m_rm = 0; m_en = '0;
        end else begin
            case (m_st)
                0, 1: if (!m_valid || flip_i != m_tf || int'(lane_cnt_i) != m_tc) begin
                    m_tf = flip_i; m_tc = int'(lane_cnt_i); m_valid = 1; m_en = '0; m_st = 2;
                end
                2: begin m_req = 1; m_rm = m_tf ? 3 : 0; m_cnt = 0; m_st = 3; end
                3: if (reconf_ack_i) begin
                    m_req = 0; m_af = m_tf; m_ac = m_tc; m_st = 4;
                end else if (m_cnt + 1 >= int'(timeout_i)) begin
                    m_req = 0; m_err = 1; m_st = 0;
                end else m_cnt++;
                default: begin m_en = mask_of(m_af, m_ac); m_st = 1; end
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        check("R5 lane_en", 64'(lane_en_o), 64'(m_en));
        check("R6 reconf_req", 64'(reconf_req_o), 64'(m_req));
        check("R4 reconf_master", 64'(reconf_master_o), 64'(m_rm));
        check("R4 master", 64'(master_o), 64'(m_af ? 3 : 0));
        check("R7 err", 64'(err_o), 64'(m_err));
        check("R3 phy_sym", 64'(phy_sym_o), 64'(exp_phy(m_en, m_af, m_ac, src_sym_i)));
    end

    // Acknowledge responder and data source.
    initial begin
        int wcnt = 0;
        forever begin
            @(posedge clk); #1;
            src_sym_i = {$urandom, $urandom};
            if (reconf_req_o && !reconf_ack_i && ack_delay >= 0) begin
                if (wcnt >= ack_delay) begin reconf_ack_i = 1'b1; wcnt = 0; end
                else wcnt++;
            end else begin
                reconf_ack_i = spur;
                if (!reconf_req_o) wcnt = 0;
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic apply(bit f, logic [1:0] c);
        flip_i = f; lane_cnt_i = c;
        cyc(14);
    endtask

    task automatic look(string tag, logic [3:0] en, int mst);
        @(negedge clk);
        check({tag, " enables"}, 64'(lane_en_o), 64'(en));
        check({tag, " master"}, 64'(master_o), 64'(mst));
    endtask

    initial begin
        cyc(3);
        @(negedge clk);
        check("R1 reset enables", 64'(lane_en_o), 64'd0);
        check("R1 reset idle", 64'(phy_sym_o), 64'({IDLE, IDLE, IDLE, IDLE}));
        check("R1 reset req", 64'({reconf_req_o, err_o, master_o}), 64'd0);
        @(posedge clk); #2; rst_n = 1'b1;
        cyc(14);
        look("R9 first handover", 4'hF, 0);
        apply(0, 2'd1); look("R2 normal two", 4'h3, 0);
        @(negedge clk);
        check("R10 idle upper lanes", 64'(phy_sym_o[39:20]), 64'({IDLE, IDLE}));
        apply(1, 2'd1); look("R3 flip two", 4'hC, 3);
        apply(1, 2'd2); look("R3 flip four", 4'hF, 3);
        apply(1, 2'd0); look("R3 flip one", 4'h8, 3);
        apply(0, 2'd0); look("R2 normal one", 4'h1, 0);
        apply(0, 2'd3); look("R2 code three", 4'hF, 0);
        spur = 1; cyc(4); spur = 0; cyc(2);
        look("R8 stray ack", 4'hF, 0);
        ack_delay = 6;
        flip_i = 1; lane_cnt_i = 2'd1; cyc(4);
        flip_i = 0; cyc(30);
        look("R8 late change", 4'h3, 0);
        ack_delay = 0;
        apply(1, 2'd2); look("R6 zero delay", 4'hF, 3);
        ack_delay = -1; timeout_i = 16'd4;
        apply(0, 2'd2);
        @(negedge clk);
        check("R7 timeout err", 64'({err_o, reconf_req_o, lane_en_o}), 64'h20);
        timeout_i = 16'd0;
        apply(1, 2'd0);
        @(negedge clk);
        check("R7 zero limit", 64'({err_o, lane_en_o}), 64'h10);
        ack_delay = 2; timeout_i = 16'd20;
        apply(1, 2'd1); look("R7 recovery", 4'hC, 3);
        @(negedge clk);
        check("R7 sticky", 64'(err_o), 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule